// File: doc/BRIEF.md
# Shared Memory Bank Conflict Serializer

This block takes one shared-memory access issued by a group of 16 threads, where each thread supplies a word address and an active bit. The memory behind it is split into 16 interleaved banks. The bank is chosen by the low four address bits, so the bank index is the word address modulo 16. A bank can deliver only one word per cycle. When several active threads need different words from the same bank, the access has to be spread over several cycles.

The block works out the conflict degree. This is the largest number of distinct active addresses that fall into any single bank. It then issues exactly that many passes, one per cycle. In each pass, every bank receives at most one address. That address belongs to the lowest-numbered thread still waiting on that bank. Every pending thread that asks for the same word is served alongside it as a broadcast. For each pass the block reports:
- the bank enables,
- the address presented to each bank,
- the set of threads served,
- the pass number.

It raises a done flag during the final pass.

A unit-stride access finishes in one pass. A stride of 2 takes two passes, and a stride of 8 takes eight passes. A new request is taken only while the block is idle.

Top module: `bankSerializer`

## Requirements
- R1: Thread t's address a is presented on bank a[3:0]. In the pass that serves t, bit a[3:0] of `passBankEn` is 1 and bank field a[3:0] of `passBankAddr` (bits a[3:0]*ADDR_W upward) equals a.
- R2: While busy, `conflictDegree` equals the largest number of distinct addresses among active threads that share one bank. For a nonempty mask this is at least 1.
- R3: A nonempty request produces exactly `conflictDegree` passes on consecutive cycles, starting the cycle after acceptance. `passIndex` counts 0, 1, … and `done` is high only during the last pass.
- R4: Each pass serves, in every bank, the lowest-numbered pending thread. It also serves every other pending thread with an identical address. Each bank sees at most one address per pass.
- R5: A thread whose `reqMask` bit (bit t for thread t) is 0 is never served and does not count toward the conflict degree.
- R6: Over one request, every active thread is served in exactly one pass.
- R7: `reqReady` is 0 while a request is in progress, and a `reqValid` pulse during that time has no effect on the passes.
- R8: After reset the block is idle: `reqReady`=1, `passValid`=0, `done`=0.
- R9: A request with an all-zero mask gives `done`=1 and `conflictDegree`=0 in the cycle after acceptance, with no pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqAddr | input | THREADS*ADDR_W | Word address per thread, thread t at bits t*ADDR_W upward |
| reqMask | input | THREADS | Active bit per thread |
| reqReady | output | 1 | Idle, request can be taken |
| passValid | output | 1 | A pass is issued this cycle |
| passBankEn | output | BANKS | Banks accessed in this pass |
| passBankAddr | output | BANKS*ADDR_W | Address per bank, bank b at bits b*ADDR_W upward |
| passThreads | output | THREADS | Threads served in this pass |
| passIndex | output | CNT_W | Number of the current pass, from 0 |
| conflictDegree | output | CNT_W | Number of passes the request needs |
| done | output | 1 | Last cycle of the request |

## Verification
The bench drives linear strides of 1, 2 and 8, a full broadcast, and two groups of threads that each broadcast and collide in one bank. It also covers a sparse mask whose only two threads collide, a case where a lower thread owns the address most other threads share, and an empty mask. A design that skipped broadcast detection would report 16 or 8 passes where 1 or 2 are due. A design that picked the wrong thread priority would serve a different set first. One that counted masked threads would inflate the degree of the sparse case. One that ran the empty request as a pass would show a pass or fail to finish. A request driven into a busy block checks that the remaining passes are not disturbed.

// File: rtl/bankSerPkg.sv
package bankSerPkg;
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // retire the threads served this cycle
    logic finish;   // last cycle of the request
  } serStrobe_t;
endpackage

// File: rtl/serialDatapath.sv
module serialDatapath
  import bankSerPkg::*;
#(
  parameter int THREADS = 16,
  parameter int BANKS   = 16,
  parameter int ADDR_W  = 10,
  localparam int BANK_BITS = $clog2(BANKS),
  localparam int CNT_W     = $clog2(THREADS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  serStrobe_t                strobe,
  input  logic [THREADS*ADDR_W-1:0] reqAddr,
  input  logic [THREADS-1:0]        reqMask,
  output logic                      passValid,
  output logic                      remainEmpty,
  output logic [BANKS-1:0]          passBankEn,
  output logic [BANKS*ADDR_W-1:0]   passBankAddr,
  output logic [THREADS-1:0]        passThreads,
  output logic [CNT_W-1:0]          conflictDegree
);
  logic [ADDR_W-1:0]  addrQ [THREADS];
  logic [THREADS-1:0] pendingQ, origMaskQ, served, firstUse;
  logic [BANKS-1:0]   leadFound;
  logic [ADDR_W-1:0]  leadAddr [BANKS];
  logic [CNT_W-1:0]   bankCnt [BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingQ  <= '0;
      origMaskQ <= '0;
      for (int i = 0; i < THREADS; i++) addrQ[i] <= '0;
    end else if (strobe.load) begin
      pendingQ  <= reqMask;
      origMaskQ <= reqMask;
      for (int i = 0; i < THREADS; i++) addrQ[i] <= reqAddr[i*ADDR_W +: ADDR_W];
    end else if (strobe.advance) begin
      pendingQ <= pendingQ & ~served;
    end
  end

  // Leader per bank: lowest pending thread (scan downward so the lowest wins)
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      leadFound[b] = 1'b0;
      leadAddr[b]  = '0;
      for (int i = THREADS - 1; i >= 0; i--) begin
        if (pendingQ[i] && addrQ[i][BANK_BITS-1:0] == BANK_BITS'(b)) begin
          leadFound[b] = 1'b1;
          leadAddr[b]  = addrQ[i];
        end
      end
    end
  end

  // A thread rides along when its word matches its bank's leader
  always_comb begin
    for (int i = 0; i < THREADS; i++)
      served[i] = pendingQ[i] && (leadAddr[addrQ[i][BANK_BITS-1:0]] == addrQ[i]);
  end

  // Distinct active addresses per bank and the worst bank
  always_comb begin
    for (int i = 0; i < THREADS; i++) begin
      firstUse[i] = origMaskQ[i];
      for (int j = 0; j < i; j++)
        if (origMaskQ[j] && addrQ[j] == addrQ[i]) firstUse[i] = 1'b0;
    end
    conflictDegree = '0;
    for (int b = 0; b < BANKS; b++) begin
      bankCnt[b] = '0;
      for (int i = 0; i < THREADS; i++)
        if (firstUse[i] && addrQ[i][BANK_BITS-1:0] == BANK_BITS'(b))
          bankCnt[b] = bankCnt[b] + CNT_W'(1);
      if (bankCnt[b] > conflictDegree) conflictDegree = bankCnt[b];
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_bankOut
      assign passBankAddr[gb*ADDR_W +: ADDR_W] = leadFound[gb] ? leadAddr[gb] : '0;
    end
  endgenerate

  assign passBankEn  = leadFound;
  assign passThreads = served;
  assign passValid   = |pendingQ;
  assign remainEmpty = ((pendingQ & ~served) == '0);

  p_inactive_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (passThreads & ~origMaskQ) == '0);
  p_served_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    passValid |-> passThreads != '0);
  p_pending_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> $countones(pendingQ) < $past($countones(pendingQ)));
endmodule

// File: rtl/serialControl.sv
module serialControl
  import bankSerPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             passValid,
  input  logic             remainEmpty,
  output serStrobe_t       strobe,
  output logic             reqReady,
  output logic [CNT_W-1:0] passIndex,
  output logic             done
);
  logic busyQ;

  always_comb begin
    strobe.load    = reqValid && !busyQ;
    strobe.advance = busyQ && passValid;
    strobe.finish  = busyQ && remainEmpty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ     <= 1'b0;
      passIndex <= '0;
    end else begin
      if (strobe.load) busyQ <= 1'b1;
      else if (strobe.finish) busyQ <= 1'b0;
      if (strobe.load) passIndex <= '0;
      else if (strobe.advance) passIndex <= passIndex + CNT_W'(1);
    end
  end

  assign reqReady = !busyQ;
  assign done     = strobe.finish;

  p_done_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> reqReady);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reqReady && !done) |=> !reqReady);
endmodule

// File: rtl/bankSerializer.sv
module bankSerializer
  import bankSerPkg::*;
#(
  parameter int THREADS = 16,
  parameter int BANKS   = 16,
  parameter int ADDR_W  = 10,
  localparam int CNT_W  = $clog2(THREADS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reqValid,
  input  logic [THREADS*ADDR_W-1:0] reqAddr,
  input  logic [THREADS-1:0]        reqMask,
  output logic                      reqReady,
  output logic                      passValid,
  output logic [BANKS-1:0]          passBankEn,
  output logic [BANKS*ADDR_W-1:0]   passBankAddr,
  output logic [THREADS-1:0]        passThreads,
  output logic [CNT_W-1:0]          passIndex,
  output logic [CNT_W-1:0]          conflictDegree,
  output logic                      done
);
  serStrobe_t strobe;
  logic remainEmpty;

  serialDatapath #(.THREADS(THREADS), .BANKS(BANKS), .ADDR_W(ADDR_W)) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqAddr(reqAddr), .reqMask(reqMask),
    .passValid(passValid), .remainEmpty(remainEmpty), .passBankEn(passBankEn),
    .passBankAddr(passBankAddr), .passThreads(passThreads),
    .conflictDegree(conflictDegree));

  serialControl #(.CNT_W(CNT_W)) i_control (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .passValid(passValid),
    .remainEmpty(remainEmpty), .strobe(strobe), .reqReady(reqReady),
    .passIndex(passIndex), .done(done));

  p_index_below_degree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    passValid |-> passIndex < conflictDegree);
endmodule

// File: tb/test_bankSerializer.sv
module test_bankSerializer;
  localparam int T = 16, B = 16, AW = 10, CW = 5;
  logic clk = 1'b0, rst_n = 1'b0, reqValid = 1'b0;
  logic [T*AW-1:0] reqAddr = '0;
  logic [T-1:0] reqMask = '0;
  logic reqReady, passValid, done;
  logic [B-1:0] passBankEn;
  logic [B*AW-1:0] passBankAddr;
  logic [T-1:0] passThreads;
  logic [CW-1:0] passIndex, conflictDegree;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  bankSerializer i_bankSerializer (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr), .reqMask(reqMask),
    .reqReady(reqReady), .passValid(passValid), .passBankEn(passBankEn),
    .passBankAddr(passBankAddr), .passThreads(passThreads), .passIndex(passIndex),
    .conflictDegree(conflictDegree), .done(done));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input string name, input logic [AW-1:0] a[T], input logic [T-1:0] m,
                         input int expDeg, input logic [T-1:0] ep[T], input bit poke);
    int p = 0;
    logic [T-1:0] seen = '0;
    @(negedge clk);
    for (int t = 0; t < T; t++) reqAddr[t*AW +: AW] = a[t];
    reqMask = m;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(conflictDegree == CW'(expDeg), "R2", {name, " degree"}, conflictDegree, expDeg);
    for (int guard = 0; guard < 40; guard++) begin
      reqValid = 1'b0;
      if (passValid) begin
        check(passIndex == CW'(p), "R3", {name, " index"}, passIndex, p);
        check(passThreads == ep[p], "R4", {name, " served set"}, passThreads, ep[p]);
        check((passThreads & ~m) == '0, "R5", {name, " inactive served"}, passThreads, m);
        check((passThreads & seen) == '0, "R6", {name, " served twice"}, passThreads, seen);
        for (int t = 0; t < T; t++)
          if (passThreads[t]) begin
            check(passBankEn[a[t][3:0]] && passBankAddr[a[t][3:0]*AW +: AW] == a[t], "R1",
                  {name, " bank address"}, passBankAddr[a[t][3:0]*AW +: AW], a[t]);
          end
        check(done == (p == expDeg - 1), "R3", {name, " done timing"}, done, p == expDeg - 1);
        seen |= passThreads;
        p++;
        if (poke && p == 2) begin
          check(reqReady == 1'b0, "R7", {name, " ready while busy"}, reqReady, 0);
          reqAddr = '0; reqMask = '1; reqValid = 1'b1;
        end
      end
      if (done) break;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(p == expDeg, "R3", {name, " pass count"}, p, expDeg);
    check(seen == m, "R6", {name, " coverage"}, seen, m);
    @(negedge clk);
    check(reqReady == 1'b1, "R3", {name, " idle after done"}, reqReady, 1);
  endtask

  task automatic testStride1();
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(t + 32); ep[t] = '0; end
    ep[0] = 16'hFFFF;
    runCase("stride1", a, 16'hFFFF, 1, ep, 1'b0);
  endtask

  task automatic testStride2();
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(2 * t); ep[t] = '0; end
    ep[0] = 16'h00FF; ep[1] = 16'hFF00;
    runCase("stride2", a, 16'hFFFF, 2, ep, 1'b0);
  endtask

  task automatic testStride8Busy();
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(8 * t); ep[t] = '0; end
    for (int k = 0; k < 8; k++) ep[k] = 16'h3 << (2 * k);
    runCase("stride8", a, 16'hFFFF, 8, ep, 1'b1);  // R7 poke inside
  endtask

  task automatic testBroadcast();
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(5); ep[t] = '0; end
    ep[0] = 16'hFFFF;
    runCase("broadcast", a, 16'hFFFF, 1, ep, 1'b0);
  endtask

  task automatic testTwoGroups();
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = (t < 8) ? AW'(7) : AW'(23); ep[t] = '0; end
    ep[0] = 16'h00FF; ep[1] = 16'hFF00;
    runCase("twoGroups", a, 16'hFFFF, 2, ep, 1'b0);
  endtask

  task automatic testSparseMask();  // R5: only threads 0 and 15 active
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(16 * t); ep[t] = '0; end
    ep[0] = 16'h0001; ep[1] = 16'h8000;
    runCase("sparse", a, 16'h8001, 2, ep, 1'b0);
  endtask

  task automatic testPriority();  // R4: thread 0 leads bank 0
    logic [AW-1:0] a[T]; logic [T-1:0] ep[T];
    for (int t = 0; t < T; t++) begin a[t] = AW'(48); ep[t] = '0; end
    a[1] = AW'(16);
    ep[0] = 16'hFFFD; ep[1] = 16'h0002;
    runCase("priority", a, 16'hFFFF, 2, ep, 1'b0);
  endtask

  task automatic testEmpty();
    @(negedge clk);
    reqMask = '0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(done == 1'b1, "R9", "empty done", done, 1);
    check(passValid == 1'b0, "R9", "empty no pass", passValid, 0);
    check(conflictDegree == '0, "R9", "empty degree", conflictDegree, 0);
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "empty idle", reqReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "reset ready", reqReady, 1);
    check(passValid == 1'b0, "R8", "reset passValid", passValid, 0);
    check(done == 1'b0, "R8", "reset done", done, 0);
    testStride1();
    testStride2();
    testStride8Busy();
    testBroadcast();
    testTwoGroups();
    testSparseMask();
    testPriority();
    testEmpty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule